// File: doc/BRIEF.md
# Gapped-Bit Desynchronizer FIFO

This block smooths a tributary bit stream that comes out of a high-rate frame demapper in irregular bursts. For example, T1 or E1 bits are pulled from a 6480-bit, 125 µs frame clocked at 51.84 MHz. A bit enters the FIFO on every cycle where the write strobe marks it as valid. The read side is paced by a programmable divider. That divider produces one tick every `div_ratio` cycles of the same 51.84 MHz clock, and the ratio is chosen so that the tick rate lies just above the tributary rate. A ratio of 33 gives about 1.571 MHz for T1. A ratio of 25 gives about 2.074 MHz for E1.

On each tick the oldest stored bit is released as a one-cycle clock-enable strobe with its data bit. When the FIFO is empty on a tick, the strobe is withheld and an underflow event is counted. The downstream line side therefore sees a nearly uniform clock with an occasional missing pulse, instead of the bursty input. The whole block runs in one clock domain with a synchronous reset.

The write side follows valid/ready naming, but the demapper cannot be stalled. `in_ready` is advisory and is low exactly while the FIFO is full. A bit offered while `in_ready` is low is dropped and latches the overflow flag. The output side has no back-pressure: a strobe is a completed transfer.

Top module: `gapped_desync`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the FIFO, clears the divider phase, the overflow flag and the underflow counter, and holds `out_valid` low; after reset `in_ready` is 1.
- R2: The divider ticks once every E cycles, where E is `div_ratio` when that value is 2 or more, and E is 2 for values 0 and 1. After reset is released, the first tick falls on the E-th clock edge.
- R3: On a tick with the FIFO non-empty, the oldest stored bit is removed and presented on `out_bit`, with `out_valid` high for exactly the one cycle after that edge. Bits leave in the order they were written.
- R4: On a tick with the FIFO empty, `out_valid` stays low and `underflow_count` increases by one, saturating at its all-ones value.
- R5: A bit with `in_valid` high is stored when the FIFO holds fewer than DEPTH bits before that edge. A read on the same edge does not make room. `in_ready` is high exactly when the FIFO holds fewer than DEPTH bits.
- R6: A bit offered while the FIFO holds DEPTH bits is discarded, and `overflow` goes to 1 and stays 1 until reset.
- R7: Two strobes are never closer than 2 cycles. While `div_ratio` is unchanged, successive strobes are at least E cycles apart.
- R8: A bit written on the same edge as a tick that finds the FIFO empty is not read on that tick. That tick counts as an underflow, and the bit leaves on a later tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 51.84 MHz clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a tributary bit on `in_bit` this cycle |
| in_bit | input | 1 | Tributary data bit |
| in_ready | output | 1 | Advisory: FIFO not full |
| div_ratio | input | RW (8) | Read divide ratio; values below 2 act as 2 |
| out_valid | output | 1 | One-cycle output clock-enable strobe |
| out_bit | output | 1 | Output data bit, valid with `out_valid` |
| overflow | output | 1 | Sticky: a bit was dropped on a full FIFO |
| underflow_count | output | UFW (16) | Saturating count of suppressed strobes |

## Verification
The bench builds the block with DEPTH = 8 and UFW = 4. The small FIFO lets a short burst reach the full boundary and the dropped-bit overflow. The narrow counter brings underflow saturation within about sixty idle cycles. The divide ratio is switched at run time between the T1 and E1 values, small ratios and the clamped values 0 and 1. This exercises divider phase wrap on a ratio change and back-to-back strobes at the minimum spacing.

// File: rtl/desync_pkg.sv
package desync_pkg;

  // Effective divide ratio: values below 2 are raised to 2.
  function automatic logic [7:0] clamp_ratio8(input logic [7:0] r);
    return (r < 8'd2) ? 8'd2 : r;
  endfunction

endpackage

// File: rtl/desync_fifo.sv
module desync_fifo #(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_req,
  input  logic wr_bit,
  input  logic rd_en,
  output logic rd_bit,
  output logic empty,
  output logic full,
  output logic overflow
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);
  localparam logic [AW-1:0] IDX_ONE  = AW'(1);

  logic [DEPTH-1:0] store;
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    level;
  logic             wr_ok, rd_ok;

  assign empty  = (level == '0);
  assign full   = (level == FULL_CNT);
  assign wr_ok  = wr_req && !full;
  assign rd_ok  = rd_en && !empty;
  assign rd_bit = store[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_ok) begin
        store[wp] <= wr_bit;
        wp        <= (wp == LAST_IDX) ? '0 : wp + IDX_ONE;
      end
      if (rd_ok) begin
        rp <= (rp == LAST_IDX) ? '0 : rp + IDX_ONE;
      end
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + CNT_ONE;
        2'b01:   level <= level - CNT_ONE;
        default: level <= level;
      endcase
      if (wr_req && full) overflow <= 1'b1;
    end
  end

  // R5: an accepted write with no read grows the fill level by one
  p_level_grows_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !full && !(rd_en && !empty)) |=> (level == $past(level) + CNT_ONE));

  // R6: a write on a full FIFO with no read leaves the level unchanged
  p_drop_when_full_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_req && full && !rd_en) |=> (full && overflow));

  // R6: overflow is sticky
  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

endmodule

// File: rtl/desync_divider.sv
module desync_divider #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] ratio,
  output logic          tick
);

  localparam logic [RW-1:0] ONE = RW'(1);
  localparam logic [RW-1:0] TWO = RW'(2);

  logic [RW-1:0] phase;
  logic [RW-1:0] eff;

  assign eff  = (ratio < TWO) ? TWO : ratio;
  assign tick = (phase >= eff - ONE);

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (tick) phase <= '0;
    else phase <= phase + ONE;
  end

  // R2/R7: ticks are never on adjacent cycles
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/desync_sat_ctr.sv
module desync_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] value
);

  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else if (inc && value != '1) value <= value + ONE;
  end

  // R4: an increment below the top moves the count up by exactly one
  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    (inc && value != '1) |=> (value == $past(value) + ONE));

  // R4: saturation holds the all-ones value
  p_count_sat_r4: assert property (@(posedge clk) disable iff (rst)
    (value == '1) |=> (value == '1));

endmodule

// File: rtl/gapped_desync.sv
module gapped_desync #(
  parameter int DEPTH = 64,
  parameter int RW    = 8,
  parameter int UFW   = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           in_bit,
  output logic           in_ready,
  input  logic [RW-1:0]  div_ratio,
  output logic           out_valid,
  output logic           out_bit,
  output logic           overflow,
  output logic [UFW-1:0] underflow_count
);

  logic tick, empty, full, head_bit, pop;

  desync_divider #(.RW(RW)) u_div (
    .clk(clk), .rst(rst), .ratio(div_ratio), .tick(tick)
  );

  desync_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_req(in_valid), .wr_bit(in_bit),
    .rd_en(pop), .rd_bit(head_bit), .empty(empty), .full(full),
    .overflow(overflow)
  );

  desync_sat_ctr #(.W(UFW)) u_uf (
    .clk(clk), .rst(rst), .inc(tick && empty), .value(underflow_count)
  );

  assign pop      = tick && !empty;
  assign in_ready = !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= pop;
      if (pop) out_bit <= head_bit;
    end
  end

  // R3: the strobe is one cycle wide
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R4/R8: a tick on an empty FIFO produces no strobe
  p_no_strobe_empty_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && empty) |=> !out_valid);

  // R3: a tick with data produces a strobe
  p_strobe_on_data_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !empty) |=> out_valid);

endmodule

// File: tb/gapped_desync_test.sv
module gapped_desync_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int RW = 8;
  localparam int UFW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic [RW-1:0] div_ratio = 8'd4;
  logic in_ready, out_valid, out_bit, overflow;
  logic [UFW-1:0] underflow_count;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gapped_desync #(.DEPTH(DEPTH), .RW(RW), .UFW(UFW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .div_ratio(div_ratio), .out_valid(out_valid),
    .out_bit(out_bit), .overflow(overflow), .underflow_count(underflow_count)
  );

  // Reference model built from the requirements
  bit m_q[$];
  int m_phase = 0;
  bit m_ov = 1'b0;
  int m_uf = 0;
  bit m_ov_valid = 1'b0;
  bit m_out_bit = 1'b0;

  function automatic int eff_of(input logic [RW-1:0] r);
    return (r < 2) ? 2 : int'(r);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete(); m_phase = 0; m_ov = 0; m_uf = 0; m_ov_valid = 0; m_out_bit = 0;
    end else begin
      bit tk;
      int sz;
      sz = m_q.size();
      tk = (m_phase >= eff_of(div_ratio) - 1);
      m_phase = tk ? 0 : m_phase + 1;
      m_ov_valid = 1'b0;
      if (tk && sz > 0) begin
        m_ov_valid = 1'b1;
        m_out_bit = m_q.pop_front();
      end else if (tk) begin
        if (m_uf < (1 << UFW) - 1) m_uf++;
      end
      if (in_valid) begin
        if (sz < DEPTH) m_q.push_back(in_bit);
        else m_ov = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Spacing tracking for R7
  int cyc = 0;
  int last_strobe = -1;
  bit ratio_moved = 1'b0;

  // Per-cycle comparison at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check(out_valid == m_ov_valid, "R3 out_valid", out_valid, m_ov_valid);
      if (m_ov_valid) check(out_bit == m_out_bit, "R3 out_bit", out_bit, m_out_bit);
      check(int'(underflow_count) == m_uf, "R4 underflow_count", underflow_count, m_uf);
      check(overflow == m_ov, "R6 overflow", overflow, m_ov);
      check(in_ready == (m_q.size() < DEPTH), "R5 in_ready", in_ready, m_q.size() < DEPTH);
      if (out_valid) begin
        if (last_strobe >= 0) begin
          check(cyc - last_strobe >= 2, "R7 min spacing", cyc - last_strobe, 2);
          if (!ratio_moved)
            check(cyc - last_strobe >= eff_of(div_ratio), "R7 spacing", cyc - last_strobe, eff_of(div_ratio));
        end
        last_strobe = cyc;
        ratio_moved = 1'b0;
      end
    end else begin
      last_strobe = -1;
      ratio_moved = 1'b0;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    step(2);
    check(out_valid == 0 && overflow == 0 && underflow_count == 0 && in_ready == 1,
          "R1 reset state", {out_valid, overflow, in_ready}, 3'b001);
    rst = 1'b0;
  endtask

  task automatic set_ratio(input logic [RW-1:0] r);
    div_ratio = r;
    ratio_moved = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1 and R2: ratio 4, no data -> underflow on edges 4 and 8
    set_ratio(8'd4);
    do_reset();
    step(3);
    check(underflow_count == 0, "R2 no tick before 4th edge", underflow_count, 0);
    step(1);
    check(underflow_count == 1, "R2 first tick on 4th edge", underflow_count, 1);
    // R4 saturation
    step(80);
    check(underflow_count == 4'hF, "R4 saturation", underflow_count, 15);
    check(out_valid == 0, "R4 no strobe when empty", out_valid, 0);

    // R8: write on the same edge as an empty tick
    do_reset();
    step(3);
    in_valid = 1'b1; in_bit = 1'b1;
    step(1);
    in_valid = 1'b0;
    check(out_valid == 0 && underflow_count == 1, "R8 same-edge write not read",
          {out_valid, underflow_count}, 1);
    step(4);
    check(out_valid == 1 && out_bit == 1, "R8 bit leaves on next tick", {out_valid, out_bit}, 3);

    // R5/R6: burst into a full FIFO at ratio 33
    set_ratio(8'd33);
    do_reset();
    for (int i = 0; i < 12; i++) begin
      in_valid = 1'b1; in_bit = i[0] ^ i[2];
      step(1);
      if (i == 7) check(in_ready == 0, "R5 full after DEPTH writes", in_ready, 0);
    end
    in_valid = 1'b0;
    check(overflow == 1, "R6 overflow set", overflow, 1);
    step(300);
    check(overflow == 1, "R6 overflow sticky", overflow, 1);
    check(in_ready == 1, "R5 drained", in_ready, 1);

    // R2 clamp: ratio 0 on a full FIFO gives strobes every 2 cycles
    do_reset();
    set_ratio(8'd0);
    for (int i = 0; i < DEPTH; i++) begin
      in_valid = 1'b1; in_bit = i[1];
      step(1);
    end
    in_valid = 1'b0;
    step(20);

    // Random bursty traffic with run-time ratio changes
    do_reset();
    for (int blk = 0; blk < 40; blk++) begin
      logic [RW-1:0] choices [6];
      choices = '{8'd33, 8'd25, 8'd2, 8'd0, 8'd1, 8'd5};
      set_ratio(choices[$urandom % 6]);
      for (int c = 0; c < 150; c++) begin
        in_valid = ($urandom % 100) < 8 + (($urandom % 4 == 0) ? 60 : 0);
        in_bit = $urandom % 2;
        step(1);
      end
      if (blk == 20) do_reset();
    end
    in_valid = 1'b0;
    step(400);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule